// File: doc/BRIEF.md
# Pulse-Swallow Integer Feedback Divider

This block is the feedback divider of an integer-N PLL. It takes the high-rate clock and divides it by N = 4·B + A. A fixed prescaler divides by 4 or by 5. A B counter counts prescaler periods. An A counter chooses how many of those periods are stretched to five input cycles. At the start of each output period, the first A prescaler periods run at divide-by-5. The remaining B − A periods run at divide-by-4. Each completed output period gives one single-cycle pulse to the phase detector.

The ratio inputs are double-buffered. A legal setting is copied into a shadow register on the next clock. The counters load from that shadow only when the B counter wraps, so every output period runs at one ratio from start to end. If a setting is out of range, the shadow keeps its old value and a registered flag reports the bad setting. The divider then keeps running at the last good ratio.

Top module: `pswallow_fbdiv`

## Requirements
- R1: Two consecutive output pulses are exactly 4·B + A input clocks apart. B and A are the values that were loaded at the boundary where that period began.
- R2: `div_pulse` is high for exactly one clock per output period.
- R3: Every pair with 4 ≤ B ≤ 63 and 0 ≤ A ≤ 3 is accepted and divides correctly. `cfg_invalid` stays low for all of these pairs.
- R4: `cfg_invalid` goes high one clock after the setting becomes illegal, and low one clock after it becomes legal again. A setting is illegal when B < 4, B > 63, or A ≥ B.
- R5: While the setting is illegal, the division ratio stays at the last legal value.
- R6: A new setting never changes a period that is already running. That period completes at its old length, and the new ratio starts at the next period boundary. If the setting changes several times within one period, only the last value takes effect.
- R7: Reset is synchronous and active high. While reset is asserted, both outputs are low. After reset is released, the divider runs at the default ratio of B = 4, A = 0, and the first pulse comes on the 16th rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | High-rate input clock to be divided |
| rst | input | 1 | Synchronous active-high reset |
| b_val | input | 6 | Requested B count (number of prescaler periods per output period) |
| a_val | input | 2 | Requested A count (number of divide-by-5 prescaler periods) |
| div_pulse | output | 1 | Registered one-clock pulse at the end of each output period |
| cfg_invalid | output | 1 | Registered flag: the requested B/A setting is illegal |

## Verification
The main stimulus is a sweep of all 240 legal (B, A) pairs. The sweep separates a wrong weighting of B against A, an off-by-one in either counter's reload, and a prescaler that stretches the wrong number of periods. Each change is made just after a pulse. Checking the old period's length then shows whether the ratio leaked into a period that was already running. Changes made in the middle of a period, including two changes within one period, check that only the last value is taken and only at the boundary. Illegal values of B (0, 1 and 3) check that the flag timing is correct and that the old ratio is held, as opposed to adopting the bad value or stalling.

// File: rtl/fbdiv_pkg.sv
package fbdiv_pkg;
  localparam int unsigned PRE_BASE_DEF = 4;

  // Output period length in input clocks for a given ratio.
  function automatic int unsigned period_len(int unsigned p, int unsigned b, int unsigned a);
    return p * b + a;
  endfunction
endpackage

// File: rtl/fbdiv_ratio_reg.sv
// Shadow register: takes a new ratio only when it is legal and flags bad settings.
module fbdiv_ratio_reg #(
  parameter int B_W   = 6,
  parameter int A_W   = 2,
  parameter int B_MIN = 4,
  parameter int B_MAX = 63,
  parameter int RST_B = 4,
  parameter int RST_A = 0
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [B_W-1:0] b_in,
  input  logic [A_W-1:0] a_in,
  output logic [B_W-1:0] b_shadow,
  output logic [A_W-1:0] a_shadow,
  output logic           bad_q
);
  logic [31:0] b_w;
  logic [31:0] a_w;
  logic        bad;

  assign b_w = 32'(b_in);
  assign a_w = 32'(a_in);
  assign bad = (b_w < 32'(B_MIN)) || (b_w > 32'(B_MAX)) || (a_w >= b_w);

  always_ff @(posedge clk) begin
    if (rst) begin
      b_shadow <= B_W'(RST_B);
      a_shadow <= A_W'(RST_A);
      bad_q    <= 1'b0;
    end else begin
      bad_q <= bad;
      if (!bad) begin
        b_shadow <= b_in;
        a_shadow <= a_in;
      end
    end
  end
endmodule

// File: rtl/fbdiv_prescaler.sv
// Dual-modulus prescaler: divides by PRE_BASE, or by PRE_BASE+1 while stretch is high.
module fbdiv_prescaler #(
  parameter int PRE_BASE = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic stretch,
  output logic tick
);
  localparam int PCW = $clog2(PRE_BASE + 1);

  logic [PCW-1:0] pc;
  logic [PCW-1:0] last;

  assign last = stretch ? PCW'(PRE_BASE) : PCW'(PRE_BASE - 1);
  assign tick = (pc == last);

  always_ff @(posedge clk) begin
    if (rst)       pc <= '0;
    else if (tick) pc <= '0;
    else           pc <= pc + 1'b1;
  end
endmodule

// File: rtl/fbdiv_swallow_ctr.sv
// B and A counters: B counts prescaler periods, A keeps the prescaler stretched at the period start.
module fbdiv_swallow_ctr #(
  parameter int B_W   = 6,
  parameter int A_W   = 2,
  parameter int RST_B = 4,
  parameter int RST_A = 0
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           tick,
  input  logic [B_W-1:0] b_load,
  input  logic [A_W-1:0] a_load,
  output logic           stretch,
  output logic           wrap
);
  logic [B_W-1:0] b_cnt;
  logic [A_W-1:0] a_cnt;

  assign stretch = (a_cnt != '0);
  assign wrap    = tick && (b_cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      b_cnt <= B_W'(RST_B - 1);
      a_cnt <= A_W'(RST_A);
    end else if (tick) begin
      if (b_cnt == '0) begin
        b_cnt <= b_load - 1'b1;
        a_cnt <= a_load;
      end else begin
        b_cnt <= b_cnt - 1'b1;
        if (a_cnt != '0) a_cnt <= a_cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/pswallow_fbdiv.sv
module pswallow_fbdiv #(
  parameter int B_W      = 6,
  parameter int A_W      = 2,
  parameter int PRE_BASE = fbdiv_pkg::PRE_BASE_DEF,
  parameter int B_MIN    = 4,
  parameter int B_MAX    = 63,
  parameter int RST_B    = 4,
  parameter int RST_A    = 0
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [B_W-1:0] b_val,
  input  logic [A_W-1:0] a_val,
  output logic           div_pulse,
  output logic           cfg_invalid
);
  logic [B_W-1:0] b_shadow;
  logic [A_W-1:0] a_shadow;
  logic           stretch;
  logic           pre_tick;
  logic           period_end;

  fbdiv_ratio_reg #(
    .B_W(B_W), .A_W(A_W), .B_MIN(B_MIN), .B_MAX(B_MAX), .RST_B(RST_B), .RST_A(RST_A)
  ) u_ratio (
    .clk(clk), .rst(rst), .b_in(b_val), .a_in(a_val),
    .b_shadow(b_shadow), .a_shadow(a_shadow), .bad_q(cfg_invalid)
  );

  fbdiv_prescaler #(.PRE_BASE(PRE_BASE)) u_pre (
    .clk(clk), .rst(rst), .stretch(stretch), .tick(pre_tick)
  );

  fbdiv_swallow_ctr #(
    .B_W(B_W), .A_W(A_W), .RST_B(RST_B), .RST_A(RST_A)
  ) u_ctr (
    .clk(clk), .rst(rst), .tick(pre_tick), .b_load(b_shadow), .a_load(a_shadow),
    .stretch(stretch), .wrap(period_end)
  );

  always_ff @(posedge clk) begin
    if (rst) div_pulse <= 1'b0;
    else     div_pulse <= period_end;
  end
endmodule

// File: rtl/fbdiv_checker.sv
module fbdiv_checker #(
  parameter int B_W      = 6,
  parameter int A_W      = 2,
  parameter int PRE_BASE = 4,
  parameter int B_MIN    = 4,
  parameter int B_MAX    = 63,
  parameter int RST_B    = 4,
  parameter int RST_A    = 0
) (
  input logic           clk,
  input logic           rst,
  input logic [B_W-1:0] b_val,
  input logic [A_W-1:0] a_val,
  input logic           div_pulse,
  input logic           cfg_invalid,
  input logic [B_W-1:0] b_shadow,
  input logic [A_W-1:0] a_shadow,
  input logic           stretch,
  input logic           pre_tick,
  input logic           period_end
);
  logic [15:0] cnt;
  logic [15:0] exp_cur;
  logic [15:0] exp_nxt;
  logic        req_bad;

  assign req_bad = (32'(b_val) < 32'(B_MIN)) || (32'(b_val) > 32'(B_MAX)) ||
                   (32'(a_val) >= 32'(b_val));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      exp_cur <= 16'(fbdiv_pkg::period_len(PRE_BASE, RST_B, RST_A));
      exp_nxt <= 16'(fbdiv_pkg::period_len(PRE_BASE, RST_B, RST_A));
    end else begin
      cnt <= div_pulse ? 16'd1 : cnt + 16'd1;
      if (period_end) exp_nxt <= 16'(fbdiv_pkg::period_len(PRE_BASE, 32'(b_shadow), 32'(a_shadow)));
      if (div_pulse)  exp_cur <= exp_nxt;
    end
  end

  // R1
  period_len_chk: assert property (@(posedge clk) disable iff (rst)
    div_pulse |-> (cnt == exp_cur));

  // R2
  pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
    div_pulse |=> !div_pulse);

  // R4
  flag_set_chk: assert property (@(posedge clk) disable iff (rst)
    req_bad |=> cfg_invalid);

  // R4
  flag_clr_chk: assert property (@(posedge clk) disable iff (rst)
    !req_bad |=> !cfg_invalid);

  // R5
  hold_on_bad_chk: assert property (@(posedge clk) disable iff (rst)
    req_bad |=> ($stable(b_shadow) && $stable(a_shadow)));

  // R6
  stretch_at_edge_chk: assert property (@(posedge clk) disable iff (rst)
    !pre_tick |=> $stable(stretch));

  // R7
  reset_out_chk: assert property (@(posedge clk)
    rst |=> (!div_pulse && !cfg_invalid));
endmodule

bind pswallow_fbdiv fbdiv_checker #(
  .B_W(B_W), .A_W(A_W), .PRE_BASE(PRE_BASE), .B_MIN(B_MIN), .B_MAX(B_MAX),
  .RST_B(RST_B), .RST_A(RST_A)
) u_fbdiv_chk (
  .clk(clk), .rst(rst), .b_val(b_val), .a_val(a_val), .div_pulse(div_pulse),
  .cfg_invalid(cfg_invalid), .b_shadow(b_shadow), .a_shadow(a_shadow),
  .stretch(stretch), .pre_tick(pre_tick), .period_end(period_end)
);

// File: tb/test_pswallow_fbdiv.sv
`timescale 1ns/1ps
module test_pswallow_fbdiv;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] b_val = 6'd4;
  logic [1:0] a_val = 2'd0;
  logic       div_pulse;
  logic       cfg_invalid;

  int checks = 0;
  int fails  = 0;
  int cur_n  = 16;

  always #4 clk = ~clk;

  pswallow_fbdiv i_pswallow_fbdiv (
    .clk(clk), .rst(rst), .b_val(b_val), .a_val(a_val),
    .div_pulse(div_pulse), .cfg_invalid(cfg_invalid)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Counts rising edges until div_pulse is seen at a falling edge.
  task automatic wait_pulse(output int n);
    n = 0;
    do begin
      @(posedge clk);
      n++;
      @(negedge clk);
    end while (!div_pulse && n < 400);
  endtask

  task automatic t_reset();
    int n;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R7 div_pulse in reset", int'(div_pulse), 0);
    check("R7 cfg_invalid in reset", int'(cfg_invalid), 0);
    rst = 1'b0;
    wait_pulse(n);
    check("R7 first period after reset", n, 16);
    cur_n = 16;
  endtask

  task automatic t_pulse_width();
    int n;
    @(posedge clk);
    @(negedge clk);
    check("R2 pulse width", int'(div_pulse), 0);
    wait_pulse(n);
    check("R2 period after width check", n, cur_n - 1);
  endtask

  task automatic apply(input int b, input int a);
    int n1, n2;
    b_val = 6'(b);
    a_val = 2'(a);
    wait_pulse(n1);
    check("R6 running period keeps old ratio", n1, cur_n);
    check("R3 legal pair not flagged", int'(cfg_invalid), 0);
    wait_pulse(n2);
    check("R1 period equals 4B+A", n2, 4 * b + a);
    cur_n = 4 * b + a;
  endtask

  task automatic t_sweep();
    for (int b = 4; b <= 63; b++)
      for (int a = 0; a <= 3; a++)
        apply(b, a);
  endtask

  task automatic t_midchange();
    int n;
    repeat (5) @(posedge clk);
    @(negedge clk);
    b_val = 6'd20; a_val = 2'd1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    b_val = 6'd10; a_val = 2'd2;
    wait_pulse(n);
    check("R6 mid-period change deferred", n, cur_n - 8);
    wait_pulse(n);
    check("R6 last write wins", n, 42);
    cur_n = 42;
  endtask

  task automatic t_invalid(input int bad_b);
    int n;
    b_val = 6'(bad_b); a_val = 2'd1;
    wait_pulse(n);
    check("R5 period during bad setting", n, cur_n);
    check("R4 flag high on bad B", int'(cfg_invalid), 1);
    wait_pulse(n);
    check("R5 ratio held on bad B", n, cur_n);
    b_val = 6'd7; a_val = 2'd3;
    @(posedge clk);
    @(negedge clk);
    check("R4 flag clears on legal B", int'(cfg_invalid), 0);
    wait_pulse(n);
    check("R6 recovery period old ratio", n, cur_n - 1);
    wait_pulse(n);
    check("R1 ratio after recovery", n, 31);
    cur_n = 31;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_pulse_width();
    t_midchange();
    t_invalid(0);
    t_invalid(1);
    t_invalid(3);
    t_sweep();
    t_pulse_width();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule